// File: doc/BRIEF.md
# DMA Channel Address and Transfer Counter

This block is the datapath of one DMA channel. It holds a page value, a base and a current 16-bit address, and a base and a current 16-bit count. Each accepted transfer strobe moves the current address one step and lowers the remaining count by one. The 24-bit physical address is built from the page and the current address. In byte mode the address is used as it stands. In word mode it is shifted left by one bit.

The loaded count is one less than the number of transfers. On the transfer that takes the count from 0x0000 to 0xFFFF, the block pulses terminal count. The page is never advanced, so the address wraps inside its 64 KB window in byte mode and its 128 KB window in word mode. If auto-reload is off, the channel goes idle after terminal count. If it is on, the current address and count are restored from their base copies one cycle later.

Top module: `dmaeng_channel`

## Requirements
- R1: After a synchronous active-low reset, `cur_addr`, `cur_cnt` and `phys_addr` are zero and `chan_live` and `tc_pulse` are low.
- R2: With mode bit 0 clear (byte mode), `phys_addr` equals {page, cur_addr}.
- R3: With mode bit 0 set (word mode), `phys_addr` equals {page[7:1], cur_addr, 1'b0}; page bit 0 has no effect and bit 0 of `phys_addr` is zero.
- R4: Loading a count N sets `chan_live` and makes exactly N+1 accepted transfers; a loaded 0x0000 gives terminal count on the first transfer.
- R5: With mode bit 1 clear, each accepted transfer raises `cur_addr` by one, wrapping 0xFFFF to 0x0000, and the page in `phys_addr` stays unchanged.
- R6: With mode bit 1 set, each accepted transfer lowers `cur_addr` by one, wrapping 0x0000 to 0xFFFF.
- R7: `tc_pulse` is high, in the same cycle, for an accepted transfer seen while `cur_cnt` is 0x0000; after that edge `cur_cnt` reads 0xFFFF.
- R8: With mode bit 2 clear, `chan_live` falls after terminal count; while it is low, `xfer_ack` leaves `cur_addr` and `cur_cnt` unchanged and `tc_pulse` low.
- R9: With mode bit 2 set, the cycle after terminal count restores `cur_addr` and `cur_cnt` from the last loaded values and `chan_live` stays high; an `xfer_ack` in that cycle is ignored.
- R10: A load of address or count in the same cycle as `xfer_ack` takes precedence and suppresses the transfer; loading the address leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_page | input | 1 | Load the page value |
| page_din | input | 8 | Page value |
| ld_addr | input | 1 | Load the base and current address |
| addr_din | input | 16 | Address value |
| ld_cnt | input | 1 | Load the base and current count, and arm the channel |
| cnt_din | input | 16 | Count value (transfers minus one) |
| ld_mode | input | 1 | Load the mode bits |
| mode_din | input | 3 | Bit 0 word mode, bit 1 decrement, bit 2 auto-reload |
| xfer_ack | input | 1 | Transfer acknowledged this cycle |
| phys_addr | output | 24 | Physical address of the current transfer |
| tc_pulse | output | 1 | Terminal count on this transfer |
| cur_addr | output | 16 | Current address readback |
| cur_cnt | output | 16 | Current count readback |
| chan_live | output | 1 | Channel armed and accepting transfers |

## Verification
The hardest state to reach is the one-cycle reload window after terminal count with auto-reload set. In that window the residue reads 0xFFFF, and a transfer strobe arriving then must be ignored. The bench reaches it by loading a count of one, strobing twice, then holding `xfer_ack` high through the reload cycle and checking that the restored values are untouched. Address wrap in both directions is reached by loading addresses next to 0xFFFF and 0x0000, so only a few strobes are needed.

// File: rtl/dmaeng_pkg.sv
// Shared types for the DMA channel engine.
// Mode bit order: [0] word mode, [1] address decrement, [2] auto-reload.
package dmaeng_pkg;
    typedef struct packed {
        logic autoinit;
        logic dec;
        logic word;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);
endpackage

// File: rtl/dmaeng_ctrl.sv
// Channel control: holds the mode, the armed flag and the reload-pending flag.
// Decides when a transfer is accepted and when terminal count occurs.
// Assumes loads take priority over transfers within one cycle.
module dmaeng_ctrl
    import dmaeng_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_mode,
    input  logic [MODE_W-1:0] mode_din,
    input  logic              ld_cnt,
    input  logic              ld_addr,
    input  logic              xfer_ack,
    input  logic              cnt_zero,
    output mode_t             mode_q,
    output logic              live_q,
    output logic              pend_q,
    output logic              step,
    output logic              tc
);
    // Accept a transfer only when armed, not reloading and not loading.
    always_comb begin
        step = xfer_ack && live_q && !pend_q && !ld_addr && !ld_cnt;
        tc   = step && cnt_zero;
    end

    // Mode register.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= '0;
        else if (ld_mode) mode_q <= mode_t'(mode_din);
    end

    // Armed flag and reload-pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            pend_q <= tc && mode_q.autoinit;
            if (ld_cnt)  live_q <= 1'b1;
            else if (tc) live_q <= mode_q.autoinit;
        end
    end
endmodule

// File: rtl/dmaeng_addr_unit.sv
// Address unit: page, base and current address, and the physical address mux.
// Assumes step and reload never need to act together with a load (load wins).
// The page is never advanced; the address wraps within its window.
module dmaeng_addr_unit #(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 8,
    localparam int PHYS_W = ADDR_W + PAGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_page,
    input  logic [PAGE_W-1:0] page_din,
    input  logic              ld_addr,
    input  logic [ADDR_W-1:0] addr_din,
    input  logic              reload,
    input  logic              step,
    input  logic              dec,
    input  logic              word,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [PHYS_W-1:0] phys_addr
);
    logic [PAGE_W-1:0] page_q;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] cur_q;
    logic [ADDR_W-1:0] next_addr;

    // Page register.
    always_ff @(posedge clk) begin
        if (!rst_n)       page_q <= '0;
        else if (ld_page) page_q <= page_din;
    end

    // Base address copy used by auto-reload.
    always_ff @(posedge clk) begin
        if (!rst_n)       base_q <= '0;
        else if (ld_addr) base_q <= addr_din;
    end

    // Next address with natural wrap of the address width.
    always_comb begin
        next_addr = dec ? cur_q - ADDR_W'(1) : cur_q + ADDR_W'(1);
    end

    // Current address: load, then reload, then advance.
    always_ff @(posedge clk) begin
        if (!rst_n)       cur_q <= '0;
        else if (ld_addr) cur_q <= addr_din;
        else if (reload)  cur_q <= base_q;
        else if (step)    cur_q <= next_addr;
    end

    // Physical address: byte form or word form with page bit 0 dropped.
    always_comb begin
        if (word) phys_addr = {page_q[PAGE_W-1:1], cur_q, 1'b0};
        else      phys_addr = {page_q, cur_q};
    end

    assign cur_addr = cur_q;
endmodule

// File: rtl/dmaeng_cnt_unit.sv
// Count unit: base and current count. The count holds transfers minus one
// and wraps from zero to all ones on the final transfer.
// Assumes load wins over reload and reload wins over step.
module dmaeng_cnt_unit #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_cnt,
    input  logic [CNT_W-1:0] cnt_din,
    input  logic             reload,
    input  logic             step,
    output logic [CNT_W-1:0] cur_cnt,
    output logic             cnt_zero
);
    logic [CNT_W-1:0] base_q;
    logic [CNT_W-1:0] cur_q;

    // Base count copy used by auto-reload.
    always_ff @(posedge clk) begin
        if (!rst_n)      base_q <= '0;
        else if (ld_cnt) base_q <= cnt_din;
    end

    // Current count: load, then reload, then decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)      cur_q <= '0;
        else if (ld_cnt) cur_q <= cnt_din;
        else if (reload) cur_q <= base_q;
        else if (step)   cur_q <= cur_q - CNT_W'(1);
    end

    // Zero detect for terminal count.
    always_comb cnt_zero = (cur_q == '0);

    assign cur_cnt = cur_q;
endmodule

// File: rtl/dmaeng_channel.sv
// Top of one DMA channel engine: control, address unit and count unit.
// Assumes register loads arrive as single-cycle strobes and that xfer_ack
// marks one completed transfer per cycle.
module dmaeng_channel
    import dmaeng_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 8,
    parameter int CNT_W  = 16,
    localparam int PHYS_W = ADDR_W + PAGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_page,
    input  logic [PAGE_W-1:0] page_din,
    input  logic              ld_addr,
    input  logic [ADDR_W-1:0] addr_din,
    input  logic              ld_cnt,
    input  logic [CNT_W-1:0]  cnt_din,
    input  logic              ld_mode,
    input  logic [MODE_W-1:0] mode_din,
    input  logic              xfer_ack,
    output logic [PHYS_W-1:0] phys_addr,
    output logic              tc_pulse,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CNT_W-1:0]  cur_cnt,
    output logic              chan_live
);
    mode_t mode_q;
    logic  live_q;
    logic  pend_q;
    logic  step;
    logic  tc;
    logic  cnt_zero;

    dmaeng_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_mode  (ld_mode),
        .mode_din (mode_din),
        .ld_cnt   (ld_cnt),
        .ld_addr  (ld_addr),
        .xfer_ack (xfer_ack),
        .cnt_zero (cnt_zero),
        .mode_q   (mode_q),
        .live_q   (live_q),
        .pend_q   (pend_q),
        .step     (step),
        .tc       (tc)
    );

    dmaeng_addr_unit #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_page   (ld_page),
        .page_din  (page_din),
        .ld_addr   (ld_addr),
        .addr_din  (addr_din),
        .reload    (pend_q),
        .step      (step),
        .dec       (mode_q.dec),
        .word      (mode_q.word),
        .cur_addr  (cur_addr),
        .phys_addr (phys_addr)
    );

    dmaeng_cnt_unit #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_cnt   (ld_cnt),
        .cnt_din  (cnt_din),
        .reload   (pend_q),
        .step     (step),
        .cur_cnt  (cur_cnt),
        .cnt_zero (cnt_zero)
    );

    assign tc_pulse  = tc;
    assign chan_live = live_q;
endmodule

// File: rtl/dmaeng_channel_chk.sv
// Checker for dmaeng_channel, bound to every instance of the top module.
module dmaeng_channel_chk #(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 8,
    parameter int CNT_W  = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     ld_addr,
    input logic                     ld_cnt,
    input logic                     xfer_ack,
    input logic                     tc_pulse,
    input logic                     chan_live,
    input logic [ADDR_W-1:0]        cur_addr,
    input logic [CNT_W-1:0]         cur_cnt,
    input logic [ADDR_W+PAGE_W-1:0] phys_addr,
    input logic                     m_word,
    input logic                     m_dec,
    input logic                     m_auto,
    input logic                     pend
);
    logic plain_step;
    assign plain_step = xfer_ack && chan_live && !pend && !ld_addr && !ld_cnt && !tc_pulse;

    p_word_lsb_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        m_word |-> phys_addr[0] == 1'b0);

    p_tc_needs_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |-> xfer_ack && chan_live);

    p_tc_wraps_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse && !ld_cnt |=> cur_cnt == '1);

    p_count_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        plain_step |=> cur_cnt == $past(cur_cnt) - CNT_W'(1));

    p_addr_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
        plain_step && !m_dec |=> cur_addr == $past(cur_addr) + ADDR_W'(1));

    p_addr_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
        plain_step && m_dec |=> cur_addr == $past(cur_addr) - ADDR_W'(1));

    p_idle_after_tc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse && !m_auto && !ld_cnt |=> !chan_live);

    p_idle_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_live && !ld_addr && !ld_cnt |=> $stable(cur_addr) && $stable(cur_cnt));

    p_stay_live_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse && m_auto |=> chan_live);
endmodule

bind dmaeng_channel dmaeng_channel_chk #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .CNT_W(CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_addr   (ld_addr),
    .ld_cnt    (ld_cnt),
    .xfer_ack  (xfer_ack),
    .tc_pulse  (tc_pulse),
    .chan_live (chan_live),
    .cur_addr  (cur_addr),
    .cur_cnt   (cur_cnt),
    .phys_addr (phys_addr),
    .m_word    (mode_q.word),
    .m_dec     (mode_q.dec),
    .m_auto    (mode_q.autoinit),
    .pend      (pend_q)
);

// File: tb/dmaeng_channel_tb_top.sv
module dmaeng_channel_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ld_page, ld_addr, ld_cnt, ld_mode, xfer_ack;
    logic [7:0]  page_din;
    logic [15:0] addr_din, cnt_din;
    logic [2:0]  mode_din;
    logic [23:0] phys_addr;
    logic        tc_pulse, chan_live;
    logic [15:0] cur_addr, cur_cnt;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    dmaeng_channel dut_i (
        .clk(clk), .rst_n(rst_n),
        .ld_page(ld_page), .page_din(page_din),
        .ld_addr(ld_addr), .addr_din(addr_din),
        .ld_cnt(ld_cnt), .cnt_din(cnt_din),
        .ld_mode(ld_mode), .mode_din(mode_din),
        .xfer_ack(xfer_ack),
        .phys_addr(phys_addr), .tc_pulse(tc_pulse),
        .cur_addr(cur_addr), .cur_cnt(cur_cnt), .chan_live(chan_live)
    );

    // Vector: page, address, mode, expected physical address.
    localparam logic [50:0] VEC [7] = '{
        {8'h12, 16'h3456, 3'b000, 24'h123456},
        {8'h13, 16'h3456, 3'b001, 24'h1268AC},
        {8'hFF, 16'hFFFF, 3'b000, 24'hFFFFFF},
        {8'hFF, 16'hFFFF, 3'b001, 24'hFFFFFE},
        {8'h00, 16'h8001, 3'b001, 24'h010002},
        {8'h01, 16'h0000, 3'b001, 24'h000000},
        {8'h80, 16'h00FF, 3'b010, 24'h8000FF}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        ld_page = 0; ld_addr = 0; ld_cnt = 0; ld_mode = 0; xfer_ack = 0;
    endtask

    task automatic setup(input logic [7:0] pg, input logic [15:0] ad,
                         input logic [15:0] cn, input logic [2:0] md);
        ld_page = 1; page_din = pg; ld_addr = 1; addr_din = ad;
        ld_cnt = 1; cnt_din = cn; ld_mode = 1; mode_din = md;
        tick();
        idle();
    endtask

    task automatic xfer();
        xfer_ack = 1;
        tick();
        xfer_ack = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        idle();
        page_din = 0; addr_din = 0; cnt_din = 0; mode_din = 0;
        rst_n = 0;
        @(negedge clk); tick();
        rst_n = 1;
        // R1 reset state
        chk("R1 addr", cur_addr, 0);
        chk("R1 cnt", cur_cnt, 0);
        chk("R1 phys", phys_addr, 0);
        chk("R1 live", chan_live, 0);
        chk("R1 tc", tc_pulse, 0);

        // R2 / R3 physical address composition table
        foreach (VEC[i]) begin
            setup(VEC[i][50:43], VEC[i][42:27], 16'h0004, VEC[i][26:24]);
            chk(VEC[i][24] ? "R3 word phys" : "R2 byte phys", phys_addr, VEC[i][23:0]);
        end

        // R4 R5 R7 R8: byte, increment, wrap, count 2 -> three transfers
        setup(8'h5A, 16'hFFFE, 16'h0002, 3'b000);
        chk("R4 live after load", chan_live, 1);
        xfer_ack = 1; #1;
        chk("R7 no tc first", tc_pulse, 0);
        tick();
        #1; chk("R7 no tc second", tc_pulse, 0);
        tick();
        chk("R5 addr wrap", cur_addr, 16'h0000);
        chk("R5 page kept", phys_addr, 24'h5A0000);
        chk("R4 count", cur_cnt, 16'h0000);
        #1; chk("R7 tc third", tc_pulse, 1);
        tick();
        xfer_ack = 0;
        chk("R7 residue", cur_cnt, 16'hFFFF);
        chk("R8 not live", chan_live, 0);
        chk("R5 addr after", cur_addr, 16'h0001);
        xfer_ack = 1; #1;
        chk("R8 no tc idle", tc_pulse, 0);
        tick();
        xfer_ack = 0;
        chk("R8 addr frozen", cur_addr, 16'h0001);
        chk("R8 cnt frozen", cur_cnt, 16'hFFFF);

        // R4 loaded zero -> tc on first transfer
        setup(8'h00, 16'h0100, 16'h0000, 3'b000);
        xfer_ack = 1; #1;
        chk("R4 zero tc first", tc_pulse, 1);
        tick();
        xfer_ack = 0;
        chk("R4 zero done", chan_live, 0);

        // R6 decrement with wrap
        setup(8'h00, 16'h0001, 16'h0005, 3'b010);
        xfer(); xfer();
        chk("R6 addr wrap down", cur_addr, 16'hFFFF);
        chk("R6 count", cur_cnt, 16'h0003);

        // R9 auto-reload, xfer held through reload cycle
        setup(8'h00, 16'h1234, 16'h0001, 3'b100);
        xfer();
        xfer_ack = 1; #1;
        chk("R9 tc", tc_pulse, 1);
        tick();
        chk("R9 residue window", cur_cnt, 16'hFFFF);
        chk("R9 addr window", cur_addr, 16'h1236);
        chk("R9 live kept", chan_live, 1);
        #1; chk("R9 ack ignored tc", tc_pulse, 0);
        tick();
        xfer_ack = 0;
        chk("R9 addr restored", cur_addr, 16'h1234);
        chk("R9 cnt restored", cur_cnt, 16'h0001);
        xfer();
        chk("R9 runs again", cur_cnt, 16'h0000);

        // R10 load precedence
        setup(8'h00, 16'h2000, 16'h0010, 3'b000);
        ld_cnt = 1; cnt_din = 16'h0033; xfer_ack = 1;
        tick(); idle();
        chk("R10 cnt load wins", cur_cnt, 16'h0033);
        chk("R10 addr held", cur_addr, 16'h2000);
        ld_addr = 1; addr_din = 16'h4444; xfer_ack = 1;
        tick(); idle();
        chk("R10 addr load", cur_addr, 16'h4444);
        chk("R10 cnt untouched", cur_cnt, 16'h0033);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule